// File: doc/BRIEF.md
# I2C Burst FIFO Transfer Unit

This unit adds a burst mode to an I2C master. Software loads up to 32 transmit bytes into a byte-wide push port, sets a chunk length and starts the transfer. From then on the unit feeds the bytes to the underlying byte engine one at a time, with no software involvement. For reads it collects the returned bytes into a 32-entry receive FIFO, which software drains through a byte-wide pop port. A sticky chunk-end flag and an interrupt line mark the end of each chunk.

Messages longer than one FIFO load are sent as a chain of chunks inside a single bus transaction. After a chunk that is not marked final, the unit holds the clock low and waits for a continue strobe. The next chunk then starts with no new START or address phase. A chunk that is marked final ends with STOP; in a read, its last byte is answered with NACK. A slave NACK during a write ends the transfer at once. The unit only responds while burst mode is enabled; otherwise the byte-at-a-time path of the master is in use and this unit stays idle.

Top module: `i2c_burst_unit`

## Requirements
- R1: Each `tx_push` pulse adds `tx_byte` to the transmit FIFO (depth 32). A push while the FIFO already holds 32 bytes is dropped, and the data it carried is never sent.
- R2: `rx_byte` always shows the oldest received byte, and `rx_pop` removes it. When the receive FIFO is empty, `rx_byte` reads 0 and a pop has no effect.
- R3: Bit 0 of `fifo_clr` empties the transmit FIFO, and bit 1 empties the receive FIFO.
- R4: A chunk moves exactly length+1 bytes. The length is taken from `tx_len` for a write or `rx_len` for a read, and is sampled when the chunk is started.
- R5: `xfer_start` begins the first chunk, and only its first byte request has `eng_first` = 1 (START plus address). A chunk started by `cont` never has `eng_first` set.
- R6: When `end_chunk` is 1 as a chunk starts, that chunk's last byte request carries `eng_stop` = 1. In a read, that last request also carries `eng_nak_last` = 1. Neither bit is set on any other request.
- R7: When a chunk completes, `fifo_end` goes to 1 and stays there until bit 0 of `flag_clr` is pulsed. `irq` is the OR of the two flags.
- R8: After a chunk that is not final, `scl_hold` is 1 and no byte request is made until `cont` is pulsed.
- R9: A slave NACK on a write byte ends the transfer. It sets `fifo_nack` (cleared by bit 1 of `flag_clr`), pulses `eng_halt` for one cycle, makes no further requests and does not set `fifo_end`.
- R10: While `fifo_mode` is 0, `xfer_start` is ignored: no request is made and no flag changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_mode | input | 1 | Burst mode enable |
| tx_push | input | 1 | Push `tx_byte` into the transmit FIFO |
| tx_byte | input | 8 | Transmit data |
| rx_pop | input | 1 | Pop the receive FIFO |
| rx_byte | output | 8 | Head of the receive FIFO (0 when empty) |
| fifo_clr | input | 2 | Bit 0 clears the transmit FIFO, bit 1 clears the receive FIFO |
| tx_len | input | 5 | Write chunk length minus one |
| rx_len | input | 5 | Read chunk length minus one |
| xfer_start | input | 1 | Start the first chunk |
| xfer_read | input | 1 | Direction for `xfer_start` (1 = read) |
| cont | input | 1 | Continue with the next chunk |
| end_chunk | input | 1 | Chunk being started is the final one |
| flag_clr | input | 2 | Bit 0 clears `fifo_end`, bit 1 clears `fifo_nack` |
| fifo_end | output | 1 | Chunk-complete flag |
| fifo_nack | output | 1 | Write-NACK flag |
| irq | output | 1 | Interrupt |
| scl_hold | output | 1 | Clock held low between chunks |
| eng_req | output | 1 | Byte request to the engine |
| eng_first | output | 1 | Precede this byte with START and address |
| eng_read | output | 1 | Request is a read |
| eng_wdata | output | 8 | Byte to transmit |
| eng_nak_last | output | 1 | Answer this read byte with NACK |
| eng_stop | output | 1 | Generate STOP after this byte |
| eng_halt | output | 1 | Abort with STOP after a NACK |
| eng_done | input | 1 | Engine finished the requested byte |
| eng_nack | input | 1 | Slave NACKed the written byte |
| eng_rdata | input | 8 | Byte received by the engine |

## Verification
The hardest state to reach is the pause between chained chunks. To get there, the transmit FIFO must be filled past its capacity, a full 32-byte chunk must run without the final mark, and the bench must then show that nothing moves while the clock is held. The stimulus overfills the FIFO with 33 bytes and runs the 32-byte chunk. It then checks the hold and clears the flag. Finally it pushes one fresh byte and continues with a one-byte final chunk. That byte must be sent without START and must not be the dropped 33rd byte. A separate run has the bench's engine model return a NACK on the second byte of a write, to show that the transfer is abandoned.

// File: rtl/i2c_burst_pkg.sv
package i2c_burst_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_HOLD  = 2'd3
  } burst_st_t;
endpackage

// File: rtl/burst_fifo.sv
module burst_fifo #(
  parameter int DEPTH = 32,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [AW:0]   cnt;
  logic do_push, do_pop;

  assign full    = (cnt == (AW+1)'(DEPTH));
  assign empty   = (cnt == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = empty ? '0 : mem[rptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (do_push) wptr <= (wptr == AW'(DEPTH-1)) ? '0 : wptr + 1'b1;
      if (do_pop)  rptr <= (rptr == AW'(DEPTH-1)) ? '0 : rptr + 1'b1;
      cnt <= cnt + (AW+1)'(do_push) - (AW+1)'(do_pop);
    end
  end

  // R1: a push into a full FIFO without a pop leaves it full and unchanged
  a_r1_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (full && push && !pop && !clr) |=> (full && $stable(wptr)));
  // R2: a pop of an empty FIFO leaves it empty
  a_r2_no_underflow: assert property (@(posedge clk) disable iff (rst)
    (empty && pop && !push) |=> (empty && $stable(rptr)));
endmodule

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import i2c_burst_pkg::*;
#(
  parameter int LEN_W = 5,
  parameter int W     = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fifo_mode,
  input  logic [LEN_W-1:0] tx_len,
  input  logic [LEN_W-1:0] rx_len,
  input  logic             xfer_start,
  input  logic             xfer_read,
  input  logic             cont,
  input  logic             end_chunk,
  input  logic [1:0]       flag_clr,
  input  logic [W-1:0]     tx_head,
  output logic             tx_pop,
  output logic             rx_push,
  output logic [W-1:0]     rx_din,
  output logic             fifo_end,
  output logic             fifo_nack,
  output logic             scl_hold,
  output logic             eng_req,
  output logic             eng_first,
  output logic             eng_read,
  output logic [W-1:0]     eng_wdata,
  output logic             eng_nak_last,
  output logic             eng_stop,
  output logic             eng_halt,
  input  logic             eng_done,
  input  logic             eng_nack,
  input  logic [W-1:0]     eng_rdata
);
  burst_st_t st;
  logic [LEN_W-1:0] cnt, len_q;
  logic rd_q, last_q, first_q;
  logic chunk_end, wr_nack, byte_ok;

  assign chunk_end    = (cnt == len_q);
  assign eng_req      = (st == ST_ISSUE);
  assign eng_first    = first_q && (cnt == '0);
  assign eng_read     = rd_q;
  assign eng_wdata    = rd_q ? '0 : tx_head;
  assign eng_stop     = chunk_end && last_q;
  assign eng_nak_last = rd_q && chunk_end && last_q;
  assign scl_hold     = (st == ST_HOLD);
  assign tx_pop       = eng_req && !rd_q;
  assign rx_push      = (st == ST_WAIT) && eng_done && rd_q;
  assign rx_din       = eng_rdata;
  assign wr_nack      = (st == ST_WAIT) && eng_done && eng_nack && !rd_q;
  assign byte_ok      = (st == ST_WAIT) && eng_done && !wr_nack;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE;
      cnt <= '0;
      len_q <= '0;
      rd_q <= 1'b0;
      last_q <= 1'b0;
      first_q <= 1'b0;
      fifo_end <= 1'b0;
      fifo_nack <= 1'b0;
      eng_halt <= 1'b0;
    end else begin
      eng_halt <= 1'b0;
      if (flag_clr[0]) fifo_end <= 1'b0;
      if (flag_clr[1]) fifo_nack <= 1'b0;
      unique case (st)
        ST_IDLE: if (fifo_mode && xfer_start) begin
          rd_q    <= xfer_read;
          len_q   <= xfer_read ? rx_len : tx_len;
          last_q  <= end_chunk;
          first_q <= 1'b1;
          cnt     <= '0;
          st      <= ST_ISSUE;
        end
        ST_ISSUE: st <= ST_WAIT;
        ST_WAIT: begin
          if (wr_nack) begin
            fifo_nack <= 1'b1;
            eng_halt  <= 1'b1;
            st        <= ST_IDLE;
          end else if (byte_ok) begin
            if (chunk_end) begin
              fifo_end <= 1'b1;
              st <= last_q ? ST_IDLE : ST_HOLD;
            end else begin
              cnt <= cnt + 1'b1;
              st  <= ST_ISSUE;
            end
          end
        end
        ST_HOLD: if (cont) begin
          len_q   <= rd_q ? rx_len : tx_len;
          last_q  <= end_chunk;
          first_q <= 1'b0;
          cnt     <= '0;
          st      <= ST_ISSUE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R10: burst mode off keeps the engine untouched
  a_r10_mode_off_idle: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE && !fifo_mode) |=> !eng_req);
  // R9: a write NACK is followed by a halt pulse and no request
  a_r9_nack_halts: assert property (@(posedge clk) disable iff (rst)
    ((st == ST_WAIT) && eng_done && eng_nack && !eng_read) |=> (eng_halt && !eng_req));
  // R6: a NACKed read byte always ends with STOP
  a_r6_nak_with_stop: assert property (@(posedge clk) disable iff (rst)
    (eng_req && eng_nak_last) |-> (eng_stop && eng_read));
  // R7: the chunk-end flag only rises after an engine completion
  a_r7_end_after_done: assert property (@(posedge clk) disable iff (rst)
    $rose(fifo_end) |-> $past(eng_done));
  // R8: while holding, no byte is requested
  a_r8_hold_quiet: assert property (@(posedge clk) disable iff (rst)
    (scl_hold && !cont) |=> !eng_req);
endmodule

// File: rtl/i2c_burst_unit.sv
module i2c_burst_unit #(
  parameter int DEPTH = 32,
  parameter int W     = 8,
  parameter int LEN_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fifo_mode,
  input  logic             tx_push,
  input  logic [W-1:0]     tx_byte,
  input  logic             rx_pop,
  output logic [W-1:0]     rx_byte,
  input  logic [1:0]       fifo_clr,
  input  logic [LEN_W-1:0] tx_len,
  input  logic [LEN_W-1:0] rx_len,
  input  logic             xfer_start,
  input  logic             xfer_read,
  input  logic             cont,
  input  logic             end_chunk,
  input  logic [1:0]       flag_clr,
  output logic             fifo_end,
  output logic             fifo_nack,
  output logic             irq,
  output logic             scl_hold,
  output logic             eng_req,
  output logic             eng_first,
  output logic             eng_read,
  output logic [W-1:0]     eng_wdata,
  output logic             eng_nak_last,
  output logic             eng_stop,
  output logic             eng_halt,
  input  logic             eng_done,
  input  logic             eng_nack,
  input  logic [W-1:0]     eng_rdata
);
  logic [W-1:0] tx_head, rx_din;
  logic tx_pop, rx_push;
  logic tx_full, tx_empty, rx_full, rx_empty;

  burst_fifo #(.DEPTH(DEPTH), .W(W)) u_txq (
    .clk(clk), .rst(rst), .clr(fifo_clr[0]),
    .push(tx_push), .din(tx_byte), .pop(tx_pop), .dout(tx_head),
    .full(tx_full), .empty(tx_empty));

  burst_fifo #(.DEPTH(DEPTH), .W(W)) u_rxq (
    .clk(clk), .rst(rst), .clr(fifo_clr[1]),
    .push(rx_push), .din(rx_din), .pop(rx_pop), .dout(rx_byte),
    .full(rx_full), .empty(rx_empty));

  burst_ctrl #(.LEN_W(LEN_W), .W(W)) u_ctrl (
    .clk(clk), .rst(rst), .fifo_mode(fifo_mode),
    .tx_len(tx_len), .rx_len(rx_len),
    .xfer_start(xfer_start), .xfer_read(xfer_read), .cont(cont),
    .end_chunk(end_chunk), .flag_clr(flag_clr),
    .tx_head(tx_head), .tx_pop(tx_pop), .rx_push(rx_push), .rx_din(rx_din),
    .fifo_end(fifo_end), .fifo_nack(fifo_nack), .scl_hold(scl_hold),
    .eng_req(eng_req), .eng_first(eng_first), .eng_read(eng_read),
    .eng_wdata(eng_wdata), .eng_nak_last(eng_nak_last), .eng_stop(eng_stop),
    .eng_halt(eng_halt), .eng_done(eng_done), .eng_nack(eng_nack),
    .eng_rdata(eng_rdata));

  assign irq = fifo_end | fifo_nack;

  // R1: the transmit FIFO is never popped while empty by the controller's request stream
  a_r1_tx_pop_valid: assert property (@(posedge clk) disable iff (rst)
    (eng_req && !eng_read && tx_empty) |-> (eng_wdata == '0));
  // R2: a received byte is dropped rather than overwriting when the receive FIFO is full
  a_r2_rx_full_hold: assert property (@(posedge clk) disable iff (rst)
    (rx_full && !rx_pop && !fifo_clr[1]) |=> rx_full);
  // R5: a START request never happens while the clock is held
  a_r5_first_not_held: assert property (@(posedge clk) disable iff (rst)
    eng_first |-> !scl_hold);
endmodule

// File: tb/i2c_burst_unit_tb_top.sv
module i2c_burst_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst = 1'b1;
  logic fifo_mode = 0, tx_push = 0, rx_pop = 0, xfer_start = 0, xfer_read = 0;
  logic cont = 0, end_chunk = 0, eng_done = 0, eng_nack = 0;
  logic [7:0] tx_byte = 0, eng_rdata = 0, rx_byte, eng_wdata;
  logic [1:0] fifo_clr = 0, flag_clr = 0;
  logic [4:0] tx_len = 0, rx_len = 0;
  logic fifo_end, fifo_nack, irq, scl_hold, eng_req, eng_first, eng_read;
  logic eng_nak_last, eng_stop, eng_halt;

  int errors = 0, checks = 0, req_idx = 0, nack_at = -1, pend = 0, halts = 0;
  logic [11:0] expq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_burst_unit dut_i (
    .clk(clk), .rst(rst), .fifo_mode(fifo_mode), .tx_push(tx_push), .tx_byte(tx_byte),
    .rx_pop(rx_pop), .rx_byte(rx_byte), .fifo_clr(fifo_clr), .tx_len(tx_len),
    .rx_len(rx_len), .xfer_start(xfer_start), .xfer_read(xfer_read), .cont(cont),
    .end_chunk(end_chunk), .flag_clr(flag_clr), .fifo_end(fifo_end),
    .fifo_nack(fifo_nack), .irq(irq), .scl_hold(scl_hold), .eng_req(eng_req),
    .eng_first(eng_first), .eng_read(eng_read), .eng_wdata(eng_wdata),
    .eng_nak_last(eng_nak_last), .eng_stop(eng_stop), .eng_halt(eng_halt),
    .eng_done(eng_done), .eng_nack(eng_nack), .eng_rdata(eng_rdata));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // engine model: completes each request two cycles after it is seen
  always @(negedge clk) begin
    eng_done = 0; eng_nack = 0;
    if (pend > 0) begin
      pend--;
      if (pend == 0) begin
        eng_done = 1;
        eng_rdata = 8'hA0 + 8'(req_idx - 1);
        eng_nack = (req_idx - 1 == nack_at);
      end
    end else if (eng_req) begin
      req_idx++;
      pend = 2;
    end
  end

  // monitor: compares every request with the scoreboard (R5, R6, R1)
  always @(negedge clk) begin
    if (!rst && eng_halt) halts++;
    if (!rst && eng_req) begin
      logic [11:0] got;
      got = {eng_first, eng_read, eng_nak_last, eng_stop, eng_wdata};
      if (expq.size() == 0) check(0, "R8 unexpected request", int'(got), 0);
      else begin
        logic [11:0] e;
        e = expq.pop_front();
        check(got == e, "R5/R6 request fields", int'(got), int'(e));
      end
    end
  end

  task automatic expect_req(input bit f, input bit r, input bit n, input bit s, input logic [7:0] d);
    expq.push_back({f, r, n, s, d});
  endtask

  task automatic push_tx(input logic [7:0] d);
    tx_byte = d; tx_push = 1; @(negedge clk); tx_push = 0;
  endtask

  task automatic pulse_start(input bit rd, input bit last);
    xfer_read = rd; end_chunk = last; xfer_start = 1; @(negedge clk); xfer_start = 0;
  endtask

  task automatic wait_flags();
    for (int i = 0; i < 400 && !(fifo_end || fifo_nack); i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic clear_flags();
    flag_clr = 2'b11; @(negedge clk); flag_clr = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check({fifo_end, fifo_nack, irq, scl_hold, eng_req} == 0, "R7 reset flags",
          {fifo_end, fifo_nack, irq, scl_hold, eng_req}, 0);
    check(rx_byte == 0, "R2 empty read", rx_byte, 0);

    // R10: burst mode off ignores start
    push_tx(8'h11);
    pulse_start(0, 1);
    repeat (20) @(negedge clk);
    check(fifo_end == 0 && req_idx == 0, "R10 start ignored", req_idx, 0);
    fifo_clr = 2'b01; @(negedge clk); fifo_clr = 0;
    fifo_mode = 1;

    // R4/R6/R7: three-byte final write
    push_tx(8'h31); push_tx(8'h32); push_tx(8'h33);
    expect_req(1, 0, 0, 0, 8'h31); expect_req(0, 0, 0, 0, 8'h32); expect_req(0, 0, 0, 1, 8'h33);
    tx_len = 5'd2;
    pulse_start(0, 1);
    wait_flags();
    check(fifo_end && irq, "R7 end flag set", fifo_end, 1);
    check(expq.size() == 0, "R4 write count", expq.size(), 0);
    check(!scl_hold, "R8 no hold after final", scl_hold, 0);
    flag_clr = 2'b01; @(negedge clk); flag_clr = 0;
    check(!fifo_end && !irq, "R7 flag clear", fifo_end, 0);

    // R4/R6/R2: four-byte final read
    req_idx = 0;
    expect_req(1, 1, 0, 0, 0); expect_req(0, 1, 0, 0, 0);
    expect_req(0, 1, 0, 0, 0); expect_req(0, 1, 1, 1, 0);
    rx_len = 5'd3;
    pulse_start(1, 1);
    wait_flags();
    check(expq.size() == 0, "R4 read count", expq.size(), 0);
    for (int i = 0; i < 4; i++) begin
      check(rx_byte == 8'(8'hA0 + i), "R2 read data", rx_byte, 8'hA0 + i);
      rx_pop = 1; @(negedge clk); rx_pop = 0;
    end
    check(rx_byte == 0, "R2 empty after drain", rx_byte, 0);
    rx_pop = 1; @(negedge clk); rx_pop = 0;
    check(rx_byte == 0, "R2 pop empty ignored", rx_byte, 0);
    clear_flags();

    // R1/R8/R5: overfilled 32-byte chunk, hold, then continue
    req_idx = 0;
    for (int i = 0; i < 33; i++) push_tx(8'(i + 1));
    for (int i = 0; i < 32; i++) expect_req(i == 0, 0, 0, 0, 8'(i + 1));
    tx_len = 5'd31;
    pulse_start(0, 0);
    wait_flags();
    check(scl_hold == 1, "R8 hold between chunks", scl_hold, 1);
    check(fifo_end == 1, "R7 end on non-final chunk", fifo_end, 1);
    clear_flags();
    repeat (10) @(negedge clk);
    check(expq.size() == 0 && scl_hold, "R8 quiet while held", expq.size(), 0);
    push_tx(8'hEE);
    expect_req(0, 0, 0, 1, 8'hEE);   // R1: 33rd byte was dropped
    tx_len = 5'd0; end_chunk = 1; cont = 1; @(negedge clk); cont = 0;
    wait_flags();
    check(expq.size() == 0 && !scl_hold, "R5 continue chunk done", expq.size(), 0);
    clear_flags();

    // R9: NACK on second write byte
    req_idx = 0; nack_at = 1; halts = 0;
    for (int i = 0; i < 4; i++) push_tx(8'h50 + 8'(i));
    expect_req(1, 0, 0, 0, 8'h50); expect_req(0, 0, 0, 0, 8'h51);
    tx_len = 5'd3;
    pulse_start(0, 1);
    wait_flags();
    repeat (10) @(negedge clk);
    check(fifo_nack && !fifo_end && irq, "R9 nack flags", {fifo_nack, fifo_end}, 2);
    check(halts == 1, "R9 halt pulse", halts, 1);
    check(expq.size() == 0 && req_idx == 2, "R9 no further requests", req_idx, 2);
    flag_clr = 2'b10; @(negedge clk); flag_clr = 0;
    check(!fifo_nack, "R9 nack clear", fifo_nack, 0);
    nack_at = -1;

    // R3: clearing transmit FIFO discards leftovers
    fifo_clr = 2'b01; @(negedge clk); fifo_clr = 0;
    push_tx(8'hAB);
    req_idx = 0;
    expect_req(1, 0, 0, 1, 8'hAB);
    tx_len = 5'd0;
    pulse_start(0, 1);
    wait_flags();
    check(expq.size() == 0, "R3 tx clear", expq.size(), 0);
    clear_flags();

    // R3: clearing receive FIFO
    req_idx = 0;
    expect_req(1, 1, 1, 1, 0);
    rx_len = 5'd0;
    pulse_start(1, 1);
    wait_flags();
    check(rx_byte == 8'hA0, "R3 rx before clear", rx_byte, 8'hA0);
    fifo_clr = 2'b10; @(negedge clk); fifo_clr = 0;
    check(rx_byte == 0, "R3 rx clear", rx_byte, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule